// File: doc/BRIEF.md
# Bank Contention Gate

This block sits at the request port of a cache whose data array is split into several banks. It keeps a busy window for each bank and refuses a new request when the bank that request would use is still busy. The bank is chosen from a field of address bits just above the line offset, so that consecutive lines fall into different banks. A hit that needs a response occupies its bank for the data-array access time of its type. A line fill that comes back from memory occupies its bank for the write time. If the bank is already busy, the fill lengthens the current window rather than waiting for it to end.

A refused requester waits for the `retry` strobe before it tries again. When a busy bank caused the refusal, the strobe fires in exactly the cycle that bank becomes free. When a global block from the miss-handling logic caused it, the strobe fires when that block is lifted. A mode input turns bank gating off completely. With gating off, only the global block can refuse a request.

The parameters are checked at elaboration. The bank count must be a power of two of at least 2. The interleave granularity, 2 to the power of the low bit of the field, must be at least one line. When the high-bit parameter is 0, the field is placed directly above the line offset.

Top module: `bank_contention_gate`

## Requirements
- R1: The bank index is `req_addr[LO+IDX_W-1:LO]`, where IDX_W = log2(NUM_BANKS). LO = HI+1-IDX_W, and HI is INTLV_HI, or log2(LINE_BYTES)+IDX_W-1 when INTLV_HI is 0. With 4 banks and 64-byte lines this gives bits 7:6, so 0x000 and 0x100 share bank 0 while 0x040 is bank 1.
- R2: An accepted read hit (`req_hit`=1, `req_write`=0) accepted in cycle c makes its bank refuse requests in cycles c+1 to c+A-1, with A = max(TAG_LAT, RD_LAT). The bank is free again in cycle c+A.
- R3: An accepted write hit uses A = max(TAG_LAT, WR_LAT) in the same way as R2.
- R4: A fill (`fill_valid`=1) to an idle bank in cycle c makes that bank busy in cycles c+1 to c+WR_LAT-1.
- R5: A fill to a bank whose window ends at cycle f moves the end of that window to f+WR_LAT.
- R6: When a request is refused because its bank is busy, `retry` is high for exactly one cycle, the cycle in which that bank becomes free.
- R7: While `miss_block` is 1, `req_ready` is 0. A request refused during the block raises `retry` in the first cycle in which `miss_block` is 0.
- R8: With `gate_en`=0, no request is refused because of a bank, and hits and fills do not occupy banks.
- R9: Only one bank retry is outstanding at a time. A refusal on a second bank while one is pending gets its retry only after the first retry has been issued, in the later of the cycle after the first retry and the cycle its own bank becomes free.
- R10: An accepted miss (`req_hit`=0) does not occupy its bank.
- R11: After reset all banks are idle, `req_ready` is 1 when `miss_block` is 0, and `retry` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | 1 enables per-bank gating and occupancy tracking |
| miss_block | input | 1 | Global block from the miss-handling logic |
| req_valid | input | 1 | Request valid |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_hit | input | 1 | Request hits and will use the data array |
| req_ready | output | 1 | Request accepted this cycle when valid |
| fill_valid | input | 1 | Line fill is written into the data array this cycle |
| fill_addr | input | ADDR_W | Address of the fill |
| retry | output | 1 | One-cycle strobe telling a refused requester to try again |

## Verification
The hardest case to reach from the ports is a fill that lands on a bank still inside a hit window, combined with a second refused bank waiting behind the first retry. Both the lengthened window and the held retry have to be visible at the `retry` pin. The stimulus issues a hit and then, in the very next cycle, a fill to the same bank together with a refused request. It then checks that no strobe appears where the unextended window would have ended. A separate scenario opens a write-hit window on one bank and a fill window on another that ends one cycle later. It then gets requests to both banks refused, so the two strobes must arrive in consecutive cycles in refusal order.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  // larger of two latencies, used for the data-array occupancy of a hit
  function automatic int unsigned lat_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // true when v is a power of two (and nonzero)
  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/bcg_rst_sync.sv
module bcg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/bcg_index_map.sv
module bcg_index_map #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned LO     = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);

  // bits outside the interleave field do not select a bank
  logic unused_addr_bits;
  assign unused_addr_bits = ^addr;

  assign idx = addr[LO +: IDX_W];

endmodule

// File: rtl/bcg_bank_timer.sv
module bcg_bank_timer #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned ACC_RD = 2,
  parameter int unsigned ACC_WR = 2,
  parameter int unsigned FILL   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_en,
  input  logic acc_wr,
  input  logic fill_en,
  output logic busy
);

  localparam int unsigned OFF_W = CNT_W + 2;
  localparam logic [OFF_W-1:0] CNT_MAX = {2'b00, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [OFF_W-1:0] off;

  // off = cycles from now until the window ends; the register holds off-1
  always_comb begin
    off = {2'b00, cnt_q};
    if (acc_en) begin
      off = off + OFF_W'(acc_wr ? ACC_WR : ACC_RD);
    end
    if (fill_en) begin
      off = off + OFF_W'(FILL);
    end
    if (off == '0) begin
      cnt_d = '0;
    end else if (off > CNT_MAX) begin
      cnt_d = {CNT_W{1'b1}};
    end else begin
      cnt_d = CNT_W'(off - OFF_W'(1));
    end
    cnt_en = (cnt_q != '0) | acc_en | fill_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/bcg_retry_sched.sv
module bcg_retry_sched #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bank_refuse,
  input  logic [IDX_W-1:0]     refuse_idx,
  input  logic                 glob_refuse,
  input  logic                 miss_block,
  input  logic [NUM_BANKS-1:0] bank_busy,
  output logic                 retry
);

  logic             pend_v_q, pend_v_d;
  logic [IDX_W-1:0] pend_idx_q, pend_idx_d;
  logic             hold_v_q, hold_v_d;
  logic [IDX_W-1:0] hold_idx_q, hold_idx_d;
  logic             glob_q, glob_d;
  logic             timed_fire;
  logic             glob_fire;
  logic             st_en;

  assign timed_fire = pend_v_q & ~bank_busy[pend_idx_q];
  assign glob_fire  = glob_q & ~miss_block;
  assign retry      = timed_fire | glob_fire;

  always_comb begin
    pend_v_d   = pend_v_q;
    pend_idx_d = pend_idx_q;
    hold_v_d   = hold_v_q;
    hold_idx_d = hold_idx_q;
    glob_d     = glob_q;

    if (glob_fire) begin
      glob_d = 1'b0;
    end
    if (glob_refuse) begin
      glob_d = 1'b1;
    end

    // the held refusal moves up once the pending retry is issued
    if (timed_fire) begin
      pend_v_d   = hold_v_q;
      pend_idx_d = hold_idx_q;
      hold_v_d   = 1'b0;
    end

    if (bank_refuse) begin
      if (!pend_v_d) begin
        pend_v_d   = 1'b1;
        pend_idx_d = refuse_idx;
      end else if (pend_idx_d != refuse_idx && !hold_v_d) begin
        hold_v_d   = 1'b1;
        hold_idx_d = refuse_idx;
      end
    end

    st_en = timed_fire | glob_fire | glob_refuse | bank_refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q   <= 1'b0;
      pend_idx_q <= '0;
      hold_v_q   <= 1'b0;
      hold_idx_q <= '0;
      glob_q     <= 1'b0;
    end else if (st_en) begin
      pend_v_q   <= pend_v_d;
      pend_idx_q <= pend_idx_d;
      hold_v_q   <= hold_v_d;
      hold_idx_q <= hold_idx_d;
      glob_q     <= glob_d;
    end
  end

endmodule

// File: rtl/bank_contention_gate.sv
module bank_contention_gate #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned INTLV_HI   = 0,
  parameter int unsigned TAG_LAT    = 1,
  parameter int unsigned RD_LAT     = 2,
  parameter int unsigned WR_LAT     = 2,
  parameter int unsigned CNT_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic              miss_block,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_hit,
  output logic              req_ready,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              retry
);

  localparam int unsigned IDX_W   = $clog2(NUM_BANKS);
  localparam int unsigned OFS_W   = $clog2(LINE_BYTES);
  localparam int unsigned HI      = (INTLV_HI != 0) ? INTLV_HI : OFS_W + IDX_W - 1;
  localparam int unsigned LO      = HI + 1 - IDX_W;
  localparam int unsigned ACC_RD  = bcg_pkg::lat_max(TAG_LAT, RD_LAT);
  localparam int unsigned ACC_WR  = bcg_pkg::lat_max(TAG_LAT, WR_LAT);

  // elaboration-time legality of the bank configuration
  if (!bcg_pkg::is_pow2(NUM_BANKS) || NUM_BANKS < 2) begin : g_bad_banks
    $error("bank count must be a power of two of at least 2");
  end
  if (LO < OFS_W) begin : g_bad_granule
    $error("bank interleave granularity is smaller than a line");
  end
  if (HI >= ADDR_W) begin : g_bad_hi
    $error("bank interleave field lies outside the address");
  end

  logic                 rst_q_n;
  logic [IDX_W-1:0]     req_idx;
  logic [IDX_W-1:0]     fill_idx;
  logic [NUM_BANKS-1:0] bank_busy;
  logic                 tgt_busy;
  logic                 accept;
  logic                 bank_refuse;
  logic                 glob_refuse;

  bcg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  bcg_index_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LO(LO)) u_req_map (
    .addr (req_addr),
    .idx  (req_idx)
  );

  bcg_index_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LO(LO)) u_fill_map (
    .addr (fill_addr),
    .idx  (fill_idx)
  );

  always_comb begin
    tgt_busy    = gate_en & bank_busy[req_idx];
    req_ready   = ~miss_block & ~tgt_busy;
    accept      = req_valid & req_ready;
    glob_refuse = req_valid & miss_block;
    bank_refuse = req_valid & ~miss_block & tgt_busy;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic acc_en;
    logic fill_en;

    assign acc_en  = gate_en & accept & req_hit & (req_idx == IDX_W'(b));
    assign fill_en = gate_en & fill_valid & (fill_idx == IDX_W'(b));

    bcg_bank_timer #(
      .CNT_W  (CNT_W),
      .ACC_RD (ACC_RD),
      .ACC_WR (ACC_WR),
      .FILL   (WR_LAT)
    ) u_timer (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .acc_en  (acc_en),
      .acc_wr  (req_write),
      .fill_en (fill_en),
      .busy    (bank_busy[b])
    );
  end

  bcg_retry_sched #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_sched (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .bank_refuse (bank_refuse),
    .refuse_idx  (req_idx),
    .glob_refuse (glob_refuse),
    .miss_block  (miss_block),
    .bank_busy   (bank_busy),
    .retry       (retry)
  );

endmodule

// File: rtl/bank_contention_gate_chk.sv
module bank_contention_gate_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned IDX_W     = 2,
  parameter int unsigned LO        = 6,
  parameter int unsigned ACC_RD    = 2,
  parameter int unsigned FILL      = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 gate_en,
  input logic                 miss_block,
  input logic                 req_valid,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 req_write,
  input logic                 req_hit,
  input logic                 req_ready,
  input logic                 fill_valid,
  input logic [ADDR_W-1:0]    fill_addr,
  input logic                 retry,
  input logic [NUM_BANKS-1:0] bank_busy
);

  logic             unused_chk_bits;
  logic [IDX_W-1:0] r_idx;
  logic [IDX_W-1:0] f_idx;

  assign unused_chk_bits = ^{req_addr, fill_addr};
  assign r_idx = req_addr[LO +: IDX_W];
  assign f_idx = fill_addr[LO +: IDX_W];

  assert_no_bank_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en && !miss_block) |-> req_ready);

  assert_block_refuses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_block |-> !req_ready);

  assert_unblock_retry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && miss_block) |=> (miss_block || retry));

  assert_miss_no_occupy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_hit && !bank_busy[r_idx]
     && !(fill_valid && gate_en && f_idx == r_idx)) |=> !bank_busy[$past(r_idx)]);

  if (ACC_RD > 1) begin : g_rd
    assert_read_hit_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_hit && !req_write && gate_en)
      |=> bank_busy[$past(r_idx)]);
  end

  if (FILL > 1) begin : g_fill
    assert_fill_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && gate_en) |=> bank_busy[$past(f_idx)]);
  end

endmodule

bind bank_contention_gate bank_contention_gate_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_BANKS (NUM_BANKS),
  .IDX_W     (IDX_W),
  .LO        (LO),
  .ACC_RD    (ACC_RD),
  .FILL      (WR_LAT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .gate_en    (gate_en),
  .miss_block (miss_block),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_write  (req_write),
  .req_hit    (req_hit),
  .req_ready  (req_ready),
  .fill_valid (fill_valid),
  .fill_addr  (fill_addr),
  .retry      (retry),
  .bank_busy  (bank_busy)
);

// File: tb/bank_contention_gate_tb.sv
module bank_contention_gate_tb_top;

  logic        clk;
  logic        rst_n;
  logic        gate_en;
  logic        miss_block;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_write;
  logic        req_hit;
  logic        req_ready;
  logic        fill_valid;
  logic [31:0] fill_addr;
  logic        retry;

  int checks;
  int fails;
  bit done;

  // read access 2 cycles, write access 3 cycles, fill 3 cycles
  bank_contention_gate #(
    .ADDR_W(32), .NUM_BANKS(4), .LINE_BYTES(64), .INTLV_HI(0),
    .TAG_LAT(1), .RD_LAT(2), .WR_LAT(3), .CNT_W(6)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .miss_block(miss_block),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_hit(req_hit), .req_ready(req_ready), .fill_valid(fill_valid),
    .fill_addr(fill_addr), .retry(retry)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // one cycle: inputs change at the falling edge, outputs sampled 1 ns later
  task automatic drive(input logic v, input logic [31:0] a, input logic wr,
                       input logic hit, input logic fv, input logic [31:0] fa,
                       input logic mb);
    @(negedge clk);
    req_valid  = v;
    req_addr   = a;
    req_write  = wr;
    req_hit    = hit;
    fill_valid = fv;
    fill_addr  = fa;
    miss_block = mb;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    drive(1, 32'h0, 0, 0, 0, 0, 0);
    chk("R11", "ready after reset", req_ready, 1'b1);
    chk("R11", "retry after reset", retry, 1'b0);
    idle(1);
  endtask

  task automatic t_map;
    drive(1, 32'h000, 0, 1, 0, 0, 0);                  // read hit bank 0
    chk("R2", "read hit accepted", req_ready, 1'b1);
    drive(1, 32'h040, 0, 0, 0, 0, 0);                  // bank 1 is free
    chk("R1", "0x040 maps to bank 1", req_ready, 1'b1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R10", "miss to bank 1 left it free, no retry", retry, 1'b0);
    drive(1, 32'h040, 0, 0, 0, 0, 0);
    chk("R10", "bank 1 free after miss", req_ready, 1'b1);
    idle(3);
  endtask

  task automatic t_read_window;
    drive(1, 32'h000, 0, 1, 0, 0, 0);
    chk("R2", "hit accepted", req_ready, 1'b1);
    drive(1, 32'h100, 0, 0, 0, 0, 0);                  // aliases bank 0
    chk("R1", "0x100 shares busy bank 0", req_ready, 1'b0);
    chk("R6", "no retry while busy", retry, 1'b0);
    drive(1, 32'h000, 0, 0, 0, 0, 0);
    chk("R2", "bank 0 free at c+2", req_ready, 1'b1);
    chk("R6", "retry when bank 0 frees", retry, 1'b1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R6", "retry lasts one cycle", retry, 1'b0);
    idle(3);
  endtask

  task automatic t_write_window;
    drive(1, 32'h080, 1, 1, 0, 0, 0);                  // write hit bank 2
    chk("R3", "write hit accepted", req_ready, 1'b1);
    drive(1, 32'h080, 0, 0, 0, 0, 0);
    chk("R3", "busy at c+1", req_ready, 1'b0);
    drive(1, 32'h080, 0, 0, 0, 0, 0);
    chk("R3", "busy at c+2", req_ready, 1'b0);
    chk("R6", "no retry at c+2", retry, 1'b0);
    drive(1, 32'h080, 0, 0, 0, 0, 0);
    chk("R3", "free at c+3", req_ready, 1'b1);
    chk("R6", "retry at c+3", retry, 1'b1);
    idle(3);
  endtask

  task automatic t_fill_idle;
    drive(0, 0, 0, 0, 1, 32'h040, 0);                  // fill bank 1
    drive(1, 32'h040, 0, 0, 0, 0, 0);
    chk("R4", "busy at c+1", req_ready, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R4", "still busy at c+2, no retry", retry, 1'b0);
    drive(1, 32'h040, 0, 0, 0, 0, 0);
    chk("R4", "free at c+3", req_ready, 1'b1);
    chk("R6", "retry at c+3", retry, 1'b1);
    idle(3);
  endtask

  task automatic t_fill_extend;
    drive(1, 32'h0C0, 0, 1, 0, 0, 0);                  // read hit bank 3, ends c+2
    drive(1, 32'h0C0, 0, 0, 1, 32'h0C0, 0);            // fill extends to c+5
    chk("R5", "refused at c+1", req_ready, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R5", "no retry at original end c+2", retry, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 0);
    drive(1, 32'h0C0, 0, 0, 0, 0, 0);
    chk("R5", "still busy at c+4", req_ready, 1'b0);
    chk("R5", "no retry at c+4", retry, 1'b0);
    drive(1, 32'h0C0, 0, 0, 0, 0, 0);
    chk("R5", "free at c+5", req_ready, 1'b1);
    chk("R6", "retry at extended end c+5", retry, 1'b1);
    idle(3);
  endtask

  task automatic t_global;
    drive(1, 32'h000, 0, 0, 0, 0, 1);
    chk("R7", "blocked refuses idle bank", req_ready, 1'b0);
    chk("R7", "no retry while blocked", retry, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 1);
    chk("R7", "no retry while still blocked", retry, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R7", "retry on unblock", retry, 1'b1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R7", "retry one cycle", retry, 1'b0);
    idle(2);
  endtask

  task automatic t_disabled;
    gate_en = 1'b0;
    drive(1, 32'h000, 0, 1, 0, 0, 0);
    drive(1, 32'h000, 0, 1, 1, 32'h000, 0);
    chk("R8", "no bank refusal after hit", req_ready, 1'b1);
    drive(1, 32'h000, 1, 0, 0, 0, 0);
    chk("R8", "no bank refusal after fill", req_ready, 1'b1);
    chk("R8", "no retry", retry, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 0);
    gate_en = 1'b1;
    #1;
    drive(1, 32'h000, 0, 0, 0, 0, 0);
    chk("R8", "no occupancy left behind", req_ready, 1'b1);
    idle(3);
  endtask

  task automatic t_hold;
    drive(1, 32'h000, 1, 1, 0, 0, 0);                  // bank 0 busy until c+3
    drive(1, 32'h000, 0, 0, 1, 32'h040, 0);            // bank 1 fill until c+4
    chk("R9", "bank 0 refused", req_ready, 1'b0);
    drive(1, 32'h040, 0, 0, 0, 0, 0);
    chk("R9", "bank 1 refused", req_ready, 1'b0);
    chk("R9", "no retry at c+2", retry, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R9", "first retry at c+3", retry, 1'b1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R9", "held retry at c+4", retry, 1'b1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R9", "no further retry", retry, 1'b0);
    idle(3);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; gate_en = 1'b1; miss_block = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_hit = 1'b0;
    fill_valid = 1'b0; fill_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_map;
    t_read_window;
    t_write_window;
    t_fill_idle;
    t_fill_extend;
    t_global;
    t_disabled;
    t_hold;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule